// File: doc/BRIEF.md
# ATAPI Packet Command Sequencer

This block runs one ATAPI PACKET command for a Serial ATA host port. On a start pulse it copies the needed words of a port request block out of a small word-addressed memory. It transmits the host-to-device register FIS held in that block, which carries the PACKET opcode, and then waits for the device to answer with a PIO Setup FIS. The 12- or 16-byte command packet is then sent as a data FIS. The packet bytes come from the slot that otherwise holds the first scatter-gather entry, and their length is chosen by a port-control input. FIS words leave over a valid/ready word interface and arrive over a valid/start-of-FIS word interface.

The block never looks inside the command packet. During the data phase it polices the device's traffic against two direction bits in the request block's control half-word. Read data counts into a byte counter, which is written back to the request block on successful completion. Traffic in an undeclared direction ends the command with an overrun or underrun error. A timeout limits the wait for PIO Setup.

States: IDLE, FETCH, SEND_CMD, WAIT_PIO_SETUP, SEND_PACKET, DATA_PHASE, DONE, ERROR. The transitions are:
- IDLE to FETCH on start.
- FETCH to SEND_CMD when the last slot has been captured.
- SEND_CMD to WAIT_PIO_SETUP when the last command word is accepted.
- WAIT_PIO_SETUP to SEND_PACKET on a PIO Setup FIS. It goes to DONE on a clean D2H register FIS, and to ERROR on a D2H register FIS with the error bit set or on a timeout.
- SEND_PACKET to DATA_PHASE when the last packet word is accepted.
- DATA_PHASE to DONE on a clean D2H register FIS. It goes to ERROR on a D2H register FIS with the error bit set, or on traffic in an undeclared direction.
- DONE and ERROR return to IDLE after one cycle.

Top module: `atapi_pkt_seq`

## Requirements
- R1: After reset, busy, done, error, tx_valid, mem_rd_en and mem_wr_en are all 0.
- R2: A start pulse in IDLE reads word addresses 0, 2, 3, 4, 5, 6, 8, 9, 10, 11 in that order, one per cycle with one cycle of read latency. busy stays 1 from the cycle after start until the cycle after the single done or error pulse.
- R3: The command FIS goes out as five words taken from word addresses 2..6 in order, with tx_last set only on the fifth. While tx_valid is 1 and tx_ready is 0, tx_valid, tx_data and tx_last hold steady.
- R4: Nothing follows the command FIS until a FIS whose first word has type 0x5F (bits 7:0) arrives. The packet FIS then starts with the word 0x00000046. It is followed by 3 words (pkt_len16=0) or 4 words (pkt_len16=1) from word addresses 8 upward, with tx_last set on the final word.
- R5: A D2H register FIS (type 0x34) that arrives while the block waits for PIO Setup ends the command. With status bit 16 of that word clear, the block writes 0 to word address 1 and pulses done. With bit 16 set, it pulses error with err_code 3 and writes nothing.
- R6: In the data phase with control bit 4 (word 0) set, each payload word of a device data FIS (type 0x46) adds 4 to the byte count. A clean D2H register FIS writes the count to word address 1 and pulses done.
- R7: A device data FIS in the data phase while control bit 4 is clear ends the command with err_code 1 (overrun) and no write-back.
- R8: A DMA Activate FIS (type 0x39) in the data phase while control bit 5 is clear ends the command with err_code 2 (underrun). With bit 5 set it causes no error.
- R9: If no FIS arrives during TIMEOUT cycles in WAIT_PIO_SETUP, the state moves to ERROR on the TIMEOUT-th clock edge after entry, and the error pulse carries err_code 4.
- R10: A PIO Setup FIS that arrives on the same edge as the timeout wins: the packet FIS is sent and no error is raised.
- R11: A start pulse while busy is ignored: no new memory reads are issued.
- R12: A D2H register FIS with status bit 16 set in the data phase ends the command with err_code 3 and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one command (taken in IDLE only) |
| pkt_len16 | input | 1 | Port-control packet length: 0 = 12 bytes, 1 = 16 bytes |
| mem_rd_en | output | 1 | Request-block read strobe |
| mem_addr | output | ADDR_W | Request-block word address |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_rd_en |
| mem_wr_en | output | 1 | Write-back strobe for the byte count |
| mem_wdata | output | 32 | Byte count to write back |
| tx_valid | output | 1 | Outgoing FIS word valid |
| tx_ready | input | 1 | Link accepts the outgoing word |
| tx_data | output | 32 | Outgoing FIS word |
| tx_last | output | 1 | Final word of the outgoing FIS |
| rx_valid | input | 1 | Incoming FIS word valid |
| rx_sof | input | 1 | Incoming word is the first word of a FIS |
| rx_data | input | 32 | Incoming FIS word |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle successful completion pulse |
| error | output | 1 | One-cycle error completion pulse |
| err_code | output | 3 | 0 none, 1 overrun, 2 underrun, 3 device error, 4 timeout |

## Verification
The timeout expiry and the arrival of PIO Setup can fall on the same clock edge. The bench locates the edge on which the last command word is accepted and counts TIMEOUT further edges. It drives the PIO Setup start-of-FIS word onto exactly the last edge of that count. A separate test lets that same edge pass with no FIS. The collision is judged correct if no error pulse appears in the cycle where the plain timeout test sees it, and the packet FIS header and words are emitted.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;

    localparam int WORD_W        = 32;
    localparam int PRB_SLOTS     = 10;   // ctrl + 5 FIS words + 4 packet words
    localparam int CMD_FIS_WORDS = 5;
    localparam int PKT_BASE_SLOT = 6;

    localparam logic [7:0] FIS_PIO_SETUP = 8'h5F;
    localparam logic [7:0] FIS_D2H_REG   = 8'h34;
    localparam logic [7:0] FIS_DATA      = 8'h46;
    localparam logic [7:0] FIS_DMA_ACT   = 8'h39;

    localparam int CTRL_RD_BIT    = 4;
    localparam int CTRL_WR_BIT    = 5;
    localparam int STATUS_ERR_BIT = 16;
    localparam int WB_WORD_ADDR   = 1;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_SEND_CMD, S_WAIT_PIO_SETUP,
        S_SEND_PACKET, S_DATA_PHASE, S_DONE, S_ERROR
    } seq_state_t;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_OVERRUN  = 3'd1,
        ERR_UNDERRUN = 3'd2,
        ERR_DEVICE   = 3'd3,
        ERR_TIMEOUT  = 3'd4
    } seq_err_t;

    // Capture slot to request-block word address: word 1 (count) and
    // word 7 (reserved) are skipped.
    function automatic int slot_word_addr(input int slot);
        if (slot == 0)
            return 0;
        else if (slot < PKT_BASE_SLOT)
            return slot + 1;
        else
            return slot + 2;
    endfunction

endpackage

// File: rtl/prb_fetch.sv
module prb_fetch
    import atapi_seq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SLOTS  = PRB_SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cap_valid,
    output logic [$clog2(SLOTS+1)-1:0] cap_slot,
    output logic              fin
);
    localparam int SW = $clog2(SLOTS + 1);

    logic [SW-1:0] issue_q;
    logic          active_q;
    logic          cap_valid_q;
    logic [SW-1:0] cap_slot_q;

    assign rd_en     = active_q && (issue_q < SW'(SLOTS));
    assign rd_addr   = ADDR_W'(slot_word_addr(int'(issue_q)));
    assign cap_valid = cap_valid_q;
    assign cap_slot  = cap_slot_q;
    assign fin       = cap_valid_q && (cap_slot_q == SW'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_q     <= '0;
            active_q    <= 1'b0;
            cap_valid_q <= 1'b0;
            cap_slot_q  <= '0;
        end else begin
            if (go) begin
                active_q <= 1'b1;
                issue_q  <= '0;
            end else if (rd_en) begin
                issue_q <= issue_q + 1'b1;
            end else begin
                active_q <= 1'b0;
            end
            cap_valid_q <= rd_en;
            cap_slot_q  <= issue_q;
        end
    end

    // Addresses climb strictly within one fetch burst
    assert_fetch_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr > $past(rd_addr)));

endmodule

// File: rtl/fis_tx.sv
module fis_tx #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] len,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [LEN_W-1:0] idx,
    output logic             last,
    output logic             fin
);
    logic             active_q;
    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;

    assign tx_valid = active_q;
    assign idx      = idx_q;
    assign last     = active_q && (idx_q == len_q - 1'b1);
    assign fin      = active_q && tx_ready && last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            len_q    <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            len_q    <= len;
        end else if (active_q && tx_ready) begin
            if (last)
                active_q <= 1'b0;
            else
                idx_q <= idx_q + 1'b1;
        end
    end

    // A stalled word keeps its position
    assert_tx_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !go) |=> (tx_valid && idx == $past(idx)));

endmodule

// File: rtl/rx_fis_dec.sv
module rx_fis_dec
    import atapi_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [WORD_W-1:0] rx_data,
    output logic              pio_sof,
    output logic              d2h_sof,
    output logic              d2h_err,
    output logic              data_sof,
    output logic              dact_sof,
    output logic              data_word
);
    logic [7:0] type_q;
    logic       head;

    assign head      = rx_valid && rx_sof;
    assign pio_sof   = head && (rx_data[7:0] == FIS_PIO_SETUP);
    assign d2h_sof   = head && (rx_data[7:0] == FIS_D2H_REG);
    assign d2h_err   = rx_data[STATUS_ERR_BIT];
    assign data_sof  = head && (rx_data[7:0] == FIS_DATA);
    assign dact_sof  = head && (rx_data[7:0] == FIS_DMA_ACT);
    assign data_word = rx_valid && !rx_sof && (type_q == FIS_DATA);

    always_ff @(posedge clk) begin
        if (!rst_n)
            type_q <= 8'h00;
        else if (head)
            type_q <= rx_data[7:0];
    end

endmodule

// File: rtl/atapi_pkt_seq.sv
module atapi_pkt_seq
    import atapi_seq_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int TIMEOUT = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pkt_len16,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              mem_wr_en,
    output logic [31:0]       mem_wdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    output logic              tx_last,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [31:0]       rx_data,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [2:0]        err_code
);
    localparam int SW    = $clog2(PRB_SLOTS + 1);
    localparam int LEN_W = 3;
    localparam int TO_W  = $clog2(TIMEOUT + 1);

    seq_state_t st_q, st_d;
    seq_err_t   err_q, err_sel;

    logic [WORD_W-1:0] slot_q [PRB_SLOTS];
    logic              len16_q;
    logic [WORD_W-1:0] xfer_q;
    logic [TO_W-1:0]   to_q;

    logic              f_rd_en, f_cap, f_fin;
    logic [ADDR_W-1:0] f_addr;
    logic [SW-1:0]     f_slot;

    logic              t_go, t_fin;
    logic [LEN_W-1:0]  t_len, t_idx;

    logic pio_sof, d2h_sof, d2h_err, data_sof, dact_sof, data_word;
    logic ctrl_rd, ctrl_wr;

    assign ctrl_rd = slot_q[0][CTRL_RD_BIT];
    assign ctrl_wr = slot_q[0][CTRL_WR_BIT];

    prb_fetch #(.ADDR_W(ADDR_W), .SLOTS(PRB_SLOTS)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go(st_q == S_IDLE && start),
        .rd_en(f_rd_en), .rd_addr(f_addr),
        .cap_valid(f_cap), .cap_slot(f_slot), .fin(f_fin)
    );

    fis_tx #(.LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .go(t_go), .len(t_len),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .idx(t_idx),
        .last(tx_last), .fin(t_fin)
    );

    rx_fis_dec u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .pio_sof(pio_sof), .d2h_sof(d2h_sof),
        .d2h_err(d2h_err), .data_sof(data_sof), .dact_sof(dact_sof),
        .data_word(data_word)
    );

    // Transmit launch: command FIS after fetch, packet FIS after PIO Setup
    always_comb begin
        t_go  = 1'b0;
        t_len = LEN_W'(CMD_FIS_WORDS);
        if (st_q == S_FETCH && f_fin) begin
            t_go = 1'b1;
        end else if (st_q == S_WAIT_PIO_SETUP && pio_sof) begin
            t_go  = 1'b1;
            t_len = len16_q ? LEN_W'(5) : LEN_W'(4);
        end
    end

    // Next state and error cause
    always_comb begin
        st_d    = st_q;
        err_sel = ERR_NONE;
        unique case (st_q)
            S_IDLE:        if (start) st_d = S_FETCH;
            S_FETCH:       if (f_fin) st_d = S_SEND_CMD;
            S_SEND_CMD:    if (t_fin) st_d = S_WAIT_PIO_SETUP;
            S_WAIT_PIO_SETUP: begin
                if (pio_sof) begin
                    st_d = S_SEND_PACKET;
                end else if (d2h_sof) begin
                    st_d    = d2h_err ? S_ERROR : S_DONE;
                    err_sel = ERR_DEVICE;
                end else if (to_q == TO_W'(TIMEOUT - 1)) begin
                    st_d    = S_ERROR;
                    err_sel = ERR_TIMEOUT;
                end
            end
            S_SEND_PACKET: if (t_fin) st_d = S_DATA_PHASE;
            S_DATA_PHASE: begin
                if (data_sof && !ctrl_rd) begin
                    st_d    = S_ERROR;
                    err_sel = ERR_OVERRUN;
                end else if (dact_sof && !ctrl_wr) begin
                    st_d    = S_ERROR;
                    err_sel = ERR_UNDERRUN;
                end else if (d2h_sof) begin
                    st_d    = d2h_err ? S_ERROR : S_DONE;
                    err_sel = ERR_DEVICE;
                end
            end
            S_DONE:        st_d = S_IDLE;
            S_ERROR:       st_d = S_IDLE;
            default:       st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= S_IDLE;
        else
            st_q <= st_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PRB_SLOTS; i++)
                slot_q[i] <= '0;
            len16_q <= 1'b0;
            xfer_q  <= '0;
            to_q    <= '0;
            err_q   <= ERR_NONE;
        end else begin
            if (st_q == S_IDLE && start) begin
                len16_q <= pkt_len16;
                xfer_q  <= '0;
                err_q   <= ERR_NONE;
            end
            if (f_cap)
                slot_q[f_slot] <= mem_rdata;
            if (st_q == S_WAIT_PIO_SETUP)
                to_q <= to_q + 1'b1;
            else
                to_q <= '0;
            if (st_q == S_DATA_PHASE && data_word && ctrl_rd)
                xfer_q <= xfer_q + 32'd4;
            if (st_d == S_ERROR && st_q != S_ERROR)
                err_q <= err_sel;
        end
    end

    // Outputs
    always_comb begin
        busy      = (st_q != S_IDLE);
        done      = (st_q == S_DONE);
        error     = (st_q == S_ERROR);
        err_code  = err_q;
        mem_rd_en = f_rd_en;
        mem_wr_en = (st_q == S_DONE);
        mem_addr  = (st_q == S_DONE) ? ADDR_W'(WB_WORD_ADDR) : f_addr;
        mem_wdata = xfer_q;
        tx_data   = '0;
        unique case (st_q)
            S_SEND_CMD:    tx_data = slot_q[SW'(t_idx) + SW'(1)];
            S_SEND_PACKET: tx_data = (t_idx == '0) ? {24'h0, FIS_DATA}
                                                   : slot_q[SW'(t_idx) + SW'(PKT_BASE_SLOT - 1)];
            default:       tx_data = '0;
        endcase
    end

    // ---------------- assertions ----------------
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !tx_valid && !mem_wr_en));

    assert_one_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, error}));

    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_wb_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_addr == ADDR_W'(WB_WORD_ADDR) && !mem_rd_en && done));

    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (error && err_code == ERR_OVERRUN) |-> !ctrl_rd);

    assert_underrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (error && err_code == ERR_UNDERRUN) |-> !ctrl_wr);

    assert_timeout_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (error && err_code == ERR_TIMEOUT) |-> ($past(st_q) == S_WAIT_PIO_SETUP));

endmodule

// File: tb/atapi_pkt_seq_test.sv
module atapi_pkt_seq_test;
    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic pkt_len16 = 1'b0;
    logic mem_rd_en, mem_wr_en;
    logic [3:0]  mem_addr;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_wdata;
    logic tx_valid, tx_last;
    logic tx_ready = 1'b1;
    logic [31:0] tx_data;
    logic rx_valid = 1'b0;
    logic rx_sof = 1'b0;
    logic [31:0] rx_data = '0;
    logic busy, done, error;
    logic [2:0] err_code;

    always #4 clk = ~clk;

    atapi_pkt_seq #(.ADDR_W(4), .TIMEOUT(TO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pkt_len16(pkt_len16),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
        .busy(busy), .done(done), .error(error), .err_code(err_code)
    );

    // Request-block image and port observers
    logic [31:0] prb [16];
    logic [31:0] txw [512];
    logic        txl [512];
    logic [3:0]  rd_log [512];
    int txn = 0, rdn = 0, wbn = 0;
    logic [3:0]  wb_addr = '0;
    logic [31:0] wb_val = '0;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata   <= prb[mem_addr];
            rd_log[rdn] <= mem_addr;
            rdn         <= rdn + 1;
        end
        if (mem_wr_en) begin
            wb_addr <= mem_addr;
            wb_val  <= mem_wdata;
            wbn     <= wbn + 1;
        end
        if (tx_valid && tx_ready) begin
            txw[txn] <= tx_data;
            txl[txn] <= tx_last;
            txn      <= txn + 1;
        end
    end

    int checks = 0, failures = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_prb(input logic [31:0] ctrl, input logic [31:0] fis_base);
        for (int i = 0; i < 16; i++) prb[i] = 32'h0;
        prb[0] = ctrl;
        prb[1] = 32'hDEAD_BEEF;
        for (int k = 0; k < 5; k++) prb[2 + k] = fis_base + k;
        for (int k = 0; k < 4; k++) prb[8 + k] = 32'hA0A0_0000 + k;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic rx_fis(input logic [31:0] w0, input int npay, input logic [31:0] pay);
        @(negedge clk);
        rx_valid = 1'b1; rx_sof = 1'b1; rx_data = w0;
        for (int k = 0; k < npay; k++) begin
            @(negedge clk);
            rx_sof = 1'b0; rx_data = pay + k;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_data = '0;
    endtask

    task automatic wait_tx(input int target, input string req);
        for (int i = 0; i < 300 && txn < target; i++) @(negedge clk);
        chk(txn >= target, req, txn, target);
    endtask

    task automatic wait_end(output int kind, output logic [2:0] code);
        kind = 0; code = '0;
        for (int i = 0; i < 300; i++) begin
            if (done)  begin kind = 1; break; end
            if (error) begin kind = 2; code = err_code; break; end
            @(negedge clk);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done && !error, "R1 status idle", {busy, done, error}, 0);
        chk(!tx_valid && !mem_rd_en && !mem_wr_en, "R1 ports quiet",
            {tx_valid, mem_rd_en, mem_wr_en}, 0);
    endtask

    task automatic t_read12();
        int tb0, rb0, wb0, kind;
        logic [2:0] code;
        logic [3:0] exp_a [10];
        exp_a = '{4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10, 4'd11};
        load_prb(32'h0000_0010, 32'h1111_0000);
        pkt_len16 = 1'b0; tx_ready = 1'b1;
        tb0 = txn; rb0 = rdn; wb0 = wbn;
        pulse_start();
        chk(busy, "R2 busy after start", busy, 1);
        wait_tx(tb0 + 5, "R3 command words");
        for (int j = 0; j < 10; j++)
            chk(rd_log[rb0 + j] == exp_a[j], "R2 fetch order", rd_log[rb0 + j], exp_a[j]);
        for (int k = 0; k < 5; k++) begin
            chk(txw[tb0 + k] == 32'h1111_0000 + k, "R3 command data", txw[tb0 + k], 32'h1111_0000 + k);
            chk(txl[tb0 + k] == (k == 4), "R3 last flag", txl[tb0 + k], (k == 4));
        end
        repeat (5) @(negedge clk);
        chk(txn == tb0 + 5, "R4 hold until PIO Setup", txn, tb0 + 5);
        rx_fis(32'h0000_005F, 0, 0);
        wait_tx(tb0 + 9, "R4 packet words");
        chk(txw[tb0 + 5] == 32'h0000_0046, "R4 packet header", txw[tb0 + 5], 32'h46);
        for (int k = 0; k < 3; k++)
            chk(txw[tb0 + 6 + k] == 32'hA0A0_0000 + k, "R4 packet body", txw[tb0 + 6 + k], 32'hA0A0_0000 + k);
        chk(txl[tb0 + 8], "R4 packet last", txl[tb0 + 8], 1);
        repeat (3) @(negedge clk);
        chk(txn == tb0 + 9, "R4 twelve bytes only", txn, tb0 + 9);
        rx_fis(32'h0000_0046, 3, 32'h5555_0000);
        rx_fis(32'h0050_0034, 0, 0);
        wait_end(kind, code);
        chk(kind == 1, "R6 done", kind, 1);
        @(negedge clk);
        chk(wbn == wb0 + 1 && wb_addr == 4'd1, "R6 write-back target", wb_addr, 1);
        chk(wb_val == 32'd12, "R6 byte count", wb_val, 12);
        chk(!busy, "R2 busy drops", busy, 0);
    endtask

    task automatic t_write16_stall();
        int tb0, wb0, kind;
        logic [2:0] code;
        logic [31:0] held;
        load_prb(32'h0000_0020, 32'h2222_0000);
        pkt_len16 = 1'b1; tx_ready = 1'b0;
        tb0 = txn; wb0 = wbn;
        pulse_start();
        for (int i = 0; i < 50 && !tx_valid; i++) @(negedge clk);
        held = tx_data;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(tx_valid && tx_data == held && !tx_last, "R3 stall hold", tx_data, held);
        end
        tx_ready = 1'b1;
        wait_tx(tb0 + 5, "R3 command after stall");
        chk(txw[tb0] == 32'h2222_0000, "R3 first word after stall", txw[tb0], 32'h2222_0000);
        rx_fis(32'h0000_005F, 0, 0);
        wait_tx(tb0 + 10, "R4 sixteen-byte packet");
        chk(txw[tb0 + 9] == 32'hA0A0_0003 && txl[tb0 + 9], "R4 fourth packet word", txw[tb0 + 9], 32'hA0A0_0003);
        rx_fis(32'h0000_0039, 0, 0);
        repeat (2) @(negedge clk);
        chk(busy && !error, "R8 declared write accepted", {busy, error}, 2'b10);
        rx_fis(32'h0050_0034, 0, 0);
        wait_end(kind, code);
        chk(kind == 1, "R8 write completes", kind, 1);
        @(negedge clk);
        chk(wbn == wb0 + 1 && wb_val == 0, "R8 write count zero", wb_val, 0);
        pkt_len16 = 1'b0;
    endtask

    task automatic t_nodata();
        int tb0, rb0, wb0, kind;
        logic [2:0] code;
        load_prb(32'h0, 32'h3333_0000);
        tb0 = txn; wb0 = wbn;
        pulse_start();
        wait_tx(tb0 + 5, "R5 command sent");
        rb0 = rdn;
        pulse_start();
        repeat (3) @(negedge clk);
        chk(rdn == rb0 && busy, "R11 start ignored while busy", rdn, rb0);
        rx_fis(32'h0050_0034, 0, 0);
        wait_end(kind, code);
        chk(kind == 1, "R5 no-data done", kind, 1);
        @(negedge clk);
        chk(wbn == wb0 + 1 && wb_val == 0, "R5 count zero", wb_val, 0);
        chk(txn == tb0 + 5, "R5 no packet sent", txn, tb0 + 5);
    endtask

    task automatic t_nodata_err();
        int tb0, wb0, kind;
        logic [2:0] code;
        load_prb(32'h0, 32'h4444_0000);
        tb0 = txn; wb0 = wbn;
        pulse_start();
        wait_tx(tb0 + 5, "R5 command sent");
        rx_fis(32'h0051_0034, 0, 0);
        wait_end(kind, code);
        chk(kind == 2 && code == 3'd3, "R5 device error", {kind[1:0], code}, {2'd2, 3'd3});
        @(negedge clk);
        chk(wbn == wb0, "R5 no write-back on error", wbn, wb0);
    endtask

    task automatic t_direction(input logic [31:0] ctrl, input logic [31:0] w0,
                               input logic [2:0] exp_code, input string req);
        int tb0, wb0, kind;
        logic [2:0] code;
        load_prb(ctrl, 32'h5555_0000);
        tb0 = txn; wb0 = wbn;
        pulse_start();
        wait_tx(tb0 + 5, req);
        rx_fis(32'h0000_005F, 0, 0);
        wait_tx(tb0 + 9, req);
        rx_fis(w0, 0, 0);
        wait_end(kind, code);
        chk(kind == 2 && code == exp_code, req, {kind[1:0], code}, {2'd2, exp_code});
        @(negedge clk);
        chk(wbn == wb0, req, wbn, wb0);
    endtask

    task automatic t_data_deverr();
        int tb0, wb0, kind;
        logic [2:0] code;
        load_prb(32'h0000_0010, 32'h6666_0000);
        tb0 = txn; wb0 = wbn;
        pulse_start();
        wait_tx(tb0 + 5, "R12 command");
        rx_fis(32'h0000_005F, 0, 0);
        wait_tx(tb0 + 9, "R12 packet");
        rx_fis(32'h0000_0046, 2, 32'h7777_0000);
        rx_fis(32'h0051_0034, 0, 0);
        wait_end(kind, code);
        chk(kind == 2 && code == 3'd3, "R12 data-phase device error", {kind[1:0], code}, {2'd2, 3'd3});
        @(negedge clk);
        chk(wbn == wb0, "R12 no write-back", wbn, wb0);
    endtask

    task automatic find_cmd_last();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tx_valid && tx_last) break;
        end
    endtask

    task automatic t_timeout();
        load_prb(32'h0, 32'h8888_0000);
        tx_ready = 1'b1;
        pulse_start();
        find_cmd_last();
        repeat (TO) @(negedge clk);
        chk(!error, "R9 no error before limit", error, 0);
        @(negedge clk);
        chk(error && err_code == 3'd4, "R9 timeout on limit edge", {error, err_code}, {1'b1, 3'd4});
        @(negedge clk);
        chk(!busy, "R9 back to idle", busy, 0);
    endtask

    task automatic t_collide();
        int tb0, kind;
        logic [2:0] code;
        load_prb(32'h0, 32'h9999_0000);
        tx_ready = 1'b1;
        tb0 = txn;
        pulse_start();
        find_cmd_last();
        repeat (TO) @(negedge clk);
        rx_valid = 1'b1; rx_sof = 1'b1; rx_data = 32'h0000_005F;
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_data = '0;
        chk(!error && busy, "R10 PIO Setup beats timeout", {error, busy}, 2'b01);
        wait_tx(tb0 + 9, "R10 packet after collision");
        chk(txw[tb0 + 5] == 32'h0000_0046, "R10 packet header", txw[tb0 + 5], 32'h46);
        rx_fis(32'h0050_0034, 0, 0);
        wait_end(kind, code);
        chk(kind == 1, "R10 completes", kind, 1);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) prb[i] = 32'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read12();
        t_write16_stall();
        t_nodata();
        t_nodata_err();
        t_direction(32'h0000_0000, 32'h0000_0046, 3'd1, "R7 overrun without read bit");
        t_direction(32'h0000_0010, 32'h0000_0039, 3'd2, "R8 underrun without write bit");
        t_data_deverr();
        t_timeout();
        t_collide();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule